// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block decides, for each fetch slot of a multithreaded front end, which hardware thread is allowed to fetch. It looks at a per-thread fetch state, at two per-thread occupancy counts (one for the issue queue and one for the load/store queue), and at a policy chosen while reset is held. It answers with one grant per slot: a valid bit and a thread index. Several slots are resolved in the same cycle, and no thread appears in more than one slot.

Four policies exist. The solo policy serves a single-threaded core. The rotating policy keeps an ordered priority list in which only the threads that were granted move to the back. The two least-occupancy policies favour the thread that holds the fewest entries in the chosen queue. When the block is built for one thread, policy is ignored and the thread is granted whenever its state allows fetch. Grants are plain control outputs with no handshake. A grant that is presented counts as consumed in that cycle, so the downstream fetch logic cannot apply back-pressure. To hold off every thread, it raises the drain input.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread may be granted only when its 3-bit state code is 0 (running), 1 (idle) or 5 (cache fill complete). Codes 2 (squashing), 3 (blocked), 4 (waiting on cache response), 6 (waiting on retry) and 7 (trap pending) make it ineligible.
- R2: The 2-bit policy input is captured only while rst_n is low: 0 solo, 1 rotating, 2 least issue-queue occupancy, 3 least load/store-queue occupancy. Changing it after reset has no effect.
- R3: Rotating policy: the priority list holds thread IDs in ascending order after reset. Each slot takes the first eligible thread not already granted that cycle, scanning from the head of the list. At the next rising edge, the granted threads move to the tail in slot order, and the remaining threads keep their relative order.
- R4: Least-occupancy policies: each slot takes the eligible thread not yet granted that cycle with the smallest count, using the queue the policy selects. Ties go to the lower thread ID. The other queue's counts have no effect.
- R5: Slot 0 is resolved first. A slot is valid only when the slot before it is valid. No thread is granted in two slots of the same cycle.
- R6: While drain_req is high, no slot is valid and the rotating priority list does not change.
- R7: When no thread is eligible, every slot is invalid and the priority list does not change.
- R8: Solo policy: slot 0 always grants thread 0, whatever its state, and every other slot stays invalid.
- R9: When the block is built with one thread, the policy is ignored. Slot 0 grants thread 0 exactly when that thread is eligible under R1, and every other slot stays invalid.
- R10: While rst_n is low, every slot is invalid. Grants follow the inputs combinationally in the same cycle. An invalid slot reports thread index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; policy is captured while it is low |
| policy_cfg | input | 2 | Policy code, sampled during reset |
| drain_req | input | 1 | Suppresses all grants while high |
| thr_status | input | 3*NUM_THREADS | Per-thread fetch state code; thread t at bits [3t+2:3t] |
| iq_occ | input | OCC_W*NUM_THREADS | Per-thread issue-queue occupancy |
| lsq_occ | input | OCC_W*NUM_THREADS | Per-thread load/store-queue occupancy |
| grant_valid | output | FETCH_SLOTS | Slot s holds a grant |
| grant_tid | output | FETCH_SLOTS*TID_W | Granted thread of slot s at bits [s*TID_W +: TID_W] |

## Verification
Grants are combinational: they answer to state, counts and drain in the same cycle. The bench therefore drives inputs just after a falling edge and samples the grants one nanosecond later, before the next rising edge. The rotating list advances at the rising edge that follows a grant, so its effect is checked on the grants of the next cycle, which are sampled the same way. The policy code takes effect at the rising edges while reset is low, and the bench changes it only after reset to show that the later change is ignored.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic [2:0] {
    ST_RUN        = 3'd0,
    ST_IDLE       = 3'd1,
    ST_SQUASH     = 3'd2,
    ST_BLOCK      = 3'd3,
    ST_WAIT_RSP   = 3'd4,
    ST_FILL_DONE  = 3'd5,
    ST_WAIT_RETRY = 3'd6,
    ST_TRAP       = 3'd7
  } fetch_state_e;

  typedef enum logic [1:0] {
    POL_SOLO    = 2'd0,
    POL_ROTATE  = 2'd1,
    POL_IQ_MIN  = 2'd2,
    POL_LSQ_MIN = 2'd3
  } sel_policy_e;

  function automatic logic state_may_fetch(input logic [2:0] code);
    return (code == ST_RUN) || (code == ST_IDLE) || (code == ST_FILL_DONE);
  endfunction

endpackage

// File: rtl/fts_elig.sv
module fts_elig #(
  parameter int N = 4
) (
  input  logic [3*N-1:0] thr_status,
  output logic [N-1:0]   elig
);
  import fts_pkg::*;

  for (genvar t = 0; t < N; t++) begin : g_thr
    assign elig[t] = state_may_fetch(thr_status[3*t +: 3]);
  end
endmodule

// File: rtl/fts_rotate.sv
module fts_rotate #(
  parameter int N     = 4,
  parameter int SLOTS = 2,
  parameter int TW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        elig,
  input  logic                advance,
  output logic [SLOTS-1:0]    pick_vld,
  output logic [SLOTS*TW-1:0] pick_tid
);
  logic [TW-1:0] ord_q [N];
  logic [TW-1:0] ord_d [N];
  logic [TW-1:0] slot_tid [SLOTS];
  logic [N-1:0]  used;
  logic [TW-1:0] last_tid;
  int            idx;

  // Per-slot scan of the priority list, excluding threads taken by earlier slots
  always_comb begin
    used     = '0;
    last_tid = '0;
    for (int s = 0; s < SLOTS; s++) begin
      pick_vld[s] = 1'b0;
      slot_tid[s] = '0;
      for (int p = 0; p < N; p++) begin
        if (!pick_vld[s] && elig[ord_q[p]] && !used[ord_q[p]]) begin
          pick_vld[s] = 1'b1;
          slot_tid[s] = ord_q[p];
        end
      end
      if (pick_vld[s]) begin
        used[slot_tid[s]] = 1'b1;
        last_tid          = slot_tid[s];
      end
      pick_tid[s*TW +: TW] = slot_tid[s];
    end
    // Next order: untouched threads first, then the granted ones in slot order
    for (int p = 0; p < N; p++) ord_d[p] = ord_q[p];
    idx = 0;
    for (int p = 0; p < N; p++) begin
      if (!used[ord_q[p]]) begin
        ord_d[idx] = ord_q[p];
        idx = idx + 1;
      end
    end
    for (int s = 0; s < SLOTS; s++) begin
      if (pick_vld[s]) begin
        ord_d[idx] = slot_tid[s];
        idx = idx + 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) ord_q[p] <= TW'(p);
    end else if (advance && pick_vld[0]) begin
      for (int p = 0; p < N; p++) ord_q[p] <= ord_d[p];
    end
  end

  // The list must stay a permutation of the thread IDs
  logic [N-1:0] seen_ids;
  always_comb begin
    seen_ids = '0;
    for (int p = 0; p < N; p++) seen_ids[ord_q[p]] = 1'b1;
  end

  a_r3_order_perm: assert property (@(posedge clk) disable iff (!rst_n)
    seen_ids == {N{1'b1}});

  a_r3_tail_last: assert property (@(posedge clk) disable iff (!rst_n)
    advance && pick_vld[0] |=> ord_q[N-1] == $past(last_tid));

  a_r7_hold_order: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(ord_q[0]) && $stable(ord_q[N-1]));
endmodule

// File: rtl/fts_minocc.sv
module fts_minocc #(
  parameter int N     = 4,
  parameter int SLOTS = 2,
  parameter int TW    = 2,
  parameter int CW    = 6
) (
  input  logic [N-1:0]        elig,
  input  logic [N*CW-1:0]     occ,
  output logic [SLOTS-1:0]    pick_vld,
  output logic [SLOTS*TW-1:0] pick_tid
);
  logic [N-1:0]  used;
  logic [CW-1:0] best_cnt;
  logic [TW-1:0] best_tid;

  // Strict less-than keeps the lower ID on a tie
  always_comb begin
    used     = '0;
    best_cnt = '0;
    best_tid = '0;
    for (int s = 0; s < SLOTS; s++) begin
      pick_vld[s] = 1'b0;
      best_cnt    = '0;
      best_tid    = '0;
      for (int t = 0; t < N; t++) begin
        if (elig[t] && !used[t] &&
            (!pick_vld[s] || occ[t*CW +: CW] < best_cnt)) begin
          pick_vld[s] = 1'b1;
          best_cnt    = occ[t*CW +: CW];
          best_tid    = TW'(t);
        end
      end
      if (pick_vld[s]) used[best_tid] = 1'b1;
      pick_tid[s*TW +: TW] = best_tid;
    end
  end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
  parameter int NUM_THREADS = 4,
  parameter int OCC_W       = 6,
  parameter int FETCH_SLOTS = 2,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   policy_cfg,
  input  logic                         drain_req,
  input  logic [3*NUM_THREADS-1:0]     thr_status,
  input  logic [OCC_W*NUM_THREADS-1:0] iq_occ,
  input  logic [OCC_W*NUM_THREADS-1:0] lsq_occ,
  output logic [FETCH_SLOTS-1:0]       grant_valid,
  output logic [FETCH_SLOTS*TID_W-1:0] grant_tid
);
  import fts_pkg::*;

  sel_policy_e            pol_q;
  logic [NUM_THREADS-1:0] elig;

  always_ff @(posedge clk) begin
    if (!rst_n) pol_q <= sel_policy_e'(policy_cfg);
  end

  fts_elig #(.N(NUM_THREADS)) u_elig (
    .thr_status (thr_status),
    .elig       (elig)
  );

  if (NUM_THREADS == 1) begin : g_single
    always_comb begin
      grant_valid    = '0;
      grant_tid      = '0;
      grant_valid[0] = rst_n && !drain_req && elig[0];
    end
  end else begin : g_multi
    logic [FETCH_SLOTS-1:0]       rot_vld, cnt_vld;
    logic [FETCH_SLOTS*TID_W-1:0] rot_tid, cnt_tid;
    logic                         rot_adv;
    logic [OCC_W*NUM_THREADS-1:0] occ_sel;

    assign rot_adv = rst_n && !drain_req && (pol_q == POL_ROTATE);
    assign occ_sel = (pol_q == POL_LSQ_MIN) ? lsq_occ : iq_occ;

    fts_rotate #(.N(NUM_THREADS), .SLOTS(FETCH_SLOTS), .TW(TID_W)) u_rot (
      .clk      (clk),
      .rst_n    (rst_n),
      .elig     (elig),
      .advance  (rot_adv),
      .pick_vld (rot_vld),
      .pick_tid (rot_tid)
    );

    fts_minocc #(.N(NUM_THREADS), .SLOTS(FETCH_SLOTS), .TW(TID_W), .CW(OCC_W)) u_min (
      .elig     (elig),
      .occ      (occ_sel),
      .pick_vld (cnt_vld),
      .pick_tid (cnt_tid)
    );

    always_comb begin
      grant_valid = '0;
      grant_tid   = '0;
      if (rst_n && !drain_req) begin
        unique case (pol_q)
          POL_SOLO:   grant_valid[0] = 1'b1;
          POL_ROTATE: begin
            grant_valid = rot_vld;
            grant_tid   = rot_tid;
          end
          default: begin
            grant_valid = cnt_vld;
            grant_tid   = cnt_tid;
          end
        endcase
      end
    end

    a_r1_elig_only: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid[0] && pol_q != POL_SOLO |-> elig[grant_tid[0 +: TID_W]]);

    a_r7_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
      elig == '0 && pol_q != POL_SOLO |-> grant_valid == '0);

    a_r8_solo_slot0: assert property (@(posedge clk) disable iff (!rst_n)
      pol_q == POL_SOLO && !drain_req |-> grant_valid == FETCH_SLOTS'(1) &&
                                          grant_tid[0 +: TID_W] == '0);
  end

  for (genvar s = 1; s < FETCH_SLOTS; s++) begin : g_slot_chk
    a_r5_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid[s] |-> grant_valid[s-1]);
    for (genvar r = 0; r < s; r++) begin : g_pair
      a_r5_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid[s] |-> grant_tid[s*TID_W +: TID_W] != grant_tid[r*TID_W +: TID_W]);
    end
  end

  a_r6_drain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> grant_valid == '0);

  a_r2_policy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> $stable(pol_q));
endmodule

// File: tb/fetch_thread_sel_test.sv
module fetch_thread_sel_test;
  localparam int N  = 4;
  localparam int CW = 6;
  localparam int SL = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    policy_cfg = 2'd1;
  logic          drain_req = 1'b0;
  logic [3*N-1:0]  thr_status = '0;
  logic [CW*N-1:0] iq_occ = '0;
  logic [CW*N-1:0] lsq_occ = '0;
  logic [SL-1:0]   grant_valid;
  logic [SL*2-1:0] grant_tid;

  logic [2:0]    st_one = 3'd0;
  logic [SL-1:0] one_valid;
  logic [SL-1:0] one_tid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  fetch_thread_sel #(.NUM_THREADS(N), .OCC_W(CW), .FETCH_SLOTS(SL)) uut (
    .clk(clk), .rst_n(rst_n), .policy_cfg(policy_cfg), .drain_req(drain_req),
    .thr_status(thr_status), .iq_occ(iq_occ), .lsq_occ(lsq_occ),
    .grant_valid(grant_valid), .grant_tid(grant_tid)
  );

  fetch_thread_sel #(.NUM_THREADS(1), .OCC_W(CW), .FETCH_SLOTS(SL)) uut_one (
    .clk(clk), .rst_n(rst_n), .policy_cfg(policy_cfg), .drain_req(drain_req),
    .thr_status(st_one), .iq_occ(iq_occ[CW-1:0]), .lsq_occ(lsq_occ[CW-1:0]),
    .grant_valid(one_valid), .grant_tid(one_tid)
  );

  function automatic logic [3*N-1:0] sts(input int a, input int b, input int c, input int d);
    return {3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  function automatic logic [CW*N-1:0] cnts(input int a, input int b, input int c, input int d);
    return {CW'(d), CW'(c), CW'(b), CW'(a)};
  endfunction

  // Called right after a falling edge; samples mid-cycle, then moves on one cycle
  task automatic expect2(input string req, input bit v0, input int t0, input bit v1, input int t1);
    int g0, g1;
    #1;
    g0 = grant_valid[0] ? int'(grant_tid[1:0]) : -1;
    g1 = grant_valid[1] ? int'(grant_tid[3:2]) : -1;
    n_tests++;
    if (grant_valid[0] !== v0 || grant_valid[1] !== v1 ||
        (v0 && g0 != t0) || (v1 && g1 != t1)) begin
      n_fail++;
      $display("FAIL %s: got slot0=%0d slot1=%0d expected slot0=%0d slot1=%0d",
               req, g0, g1, v0 ? t0 : -1, v1 ? t1 : -1);
    end
    @(negedge clk);
  endtask

  task automatic apply_reset(input int pol);
    rst_n = 1'b0;
    policy_cfg = 2'(pol);
    drain_req = 1'b0;
    thr_status = sts(0, 0, 0, 0);
    repeat (2) @(negedge clk);
    #1;
    n_tests++;
    if (grant_valid !== '0 || one_valid !== '0) begin
      n_fail++;
      $display("FAIL R10 reset: got valid=%b/%b expected 00/00", grant_valid, one_valid);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_rotate_basic();
    apply_reset(1);
    expect2("R3 ascending start", 1, 0, 1, 1);
    expect2("R3 granted to tail", 1, 2, 1, 3);
    expect2("R3 wraps", 1, 0, 1, 1);
  endtask

  task automatic t_rotate_elig();
    apply_reset(1);
    thr_status = sts(3, 1, 4, 5);
    expect2("R1 idle and fill-done only", 1, 1, 1, 3);
    thr_status = sts(0, 0, 0, 0);
    expect2("R3 others keep order", 1, 0, 1, 2);
    expect2("R3 order 1,3 next", 1, 1, 1, 3);
  endtask

  task automatic t_rotate_single();
    apply_reset(1);
    thr_status = sts(2, 6, 0, 7);
    expect2("R5 one eligible, slot1 empty", 1, 2, 0, 0);
    thr_status = sts(0, 0, 0, 0);
    expect2("R3 thread 2 moved to tail", 1, 0, 1, 1);
    expect2("R3 order 3,2 next", 1, 3, 1, 2);
  endtask

  task automatic t_none_and_drain();
    apply_reset(1);
    thr_status = sts(3, 4, 6, 2);
    expect2("R7 nothing eligible", 0, 0, 0, 0);
    thr_status = sts(0, 0, 0, 0);
    drain_req = 1'b1;
    expect2("R6 drain blocks grants", 0, 0, 0, 0);
    drain_req = 1'b0;
    expect2("R6 R7 list untouched", 1, 0, 1, 1);
  endtask

  task automatic t_iq_min();
    apply_reset(2);
    policy_cfg = 2'd1;
    iq_occ  = cnts(5, 2, 7, 2);
    lsq_occ = cnts(0, 9, 9, 9);
    expect2("R4 iq min tie low id", 1, 1, 1, 3);
    thr_status = sts(0, 3, 0, 0);
    expect2("R2 R4 policy kept after reset", 1, 3, 1, 0);
  endtask

  task automatic t_lsq_min();
    apply_reset(3);
    iq_occ  = cnts(0, 0, 9, 9);
    lsq_occ = cnts(4, 4, 1, 63);
    expect2("R4 lsq min", 1, 2, 1, 0);
    thr_status = sts(0, 0, 7, 0);
    expect2("R4 lsq min tie", 1, 0, 1, 1);
  endtask

  task automatic t_solo();
    apply_reset(0);
    thr_status = sts(3, 3, 3, 3);
    expect2("R8 solo ignores state", 1, 0, 0, 0);
    thr_status = sts(0, 0, 0, 0);
    expect2("R8 solo slot1 empty", 1, 0, 0, 0);
  endtask

  task automatic one_chk(input string req, input logic [2:0] st, input bit ev);
    st_one = st;
    #1;
    n_tests++;
    if (one_valid !== {1'b0, ev} || one_tid !== '0) begin
      n_fail++;
      $display("FAIL %s: got valid=%b tid=%b expected valid=%b tid=00",
               req, one_valid, one_tid, {1'b0, ev});
    end
    @(negedge clk);
  endtask

  task automatic t_bypass();
    apply_reset(1);
    one_chk("R9 running granted", 3'd0, 1'b1);
    one_chk("R9 retry wait refused", 3'd6, 1'b0);
    one_chk("R9 idle granted", 3'd1, 1'b1);
    one_chk("R9 blocked refused", 3'd3, 1'b0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_rotate_basic();
    t_rotate_elig();
    t_rotate_single();
    t_none_and_drain();
    t_iq_min();
    t_lsq_min();
    t_solo();
    t_bypass();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule